// File: doc/BRIEF.md
# Optical Flow Gradient Front-End

This block opens a streaming dense optical flow pipeline. Each clock it can take one greyscale pixel from the earlier frame and the co-located pixel from the later frame. Both arrive in raster order and share a valid strobe, a start-of-frame flag and an end-of-line flag. A line memory keeps the row above for both frames. Together with the pixel to the left, it forms a 2x2 window in space across the two frames. From that window the block works out the horizontal, vertical and temporal brightness gradients. All of this arithmetic is exact integer fixed-point.

For every pixel the block also computes the normalising term psi = 1 / (alpha^2 + Ix^2 + Iy^2). It uses two squarers, an adder stage and a fully pipelined restoring divider. The weight `alpha` is a run-time input. The three gradients and psi leave together, with the valid and frame flags delayed to match, so the iteration stages further down the pipeline receive one aligned record per pixel. The latency is fixed, and a new pixel can be accepted on every clock.

Top module: `optflow_grad_frontend`

## Requirements
- R1: While `rst` is high, and after it is released until new pixels have passed through, `out_valid`, `out_sof` and `out_eol` are 0. Pixels that were in flight when reset rose produce no output.
- R2: `out_ix` is a 9-bit two's-complement value equal to floor(S/4), where S = (C−L)+(U−UL) summed over both frames. C is the current pixel, L the left neighbour, U the pixel above and UL the pixel above-left.
- R3: `out_iy` is floor(S/4), where S = (C−U)+(L−UL) summed over both frames.
- R4: `out_it` is floor(S/4), where S is the sum over the four window positions of (later-frame pixel − earlier-frame pixel).
- R5: Edges are filled by copying the pixel itself. In column 0 the left and above-left pixels take the current and above values, so `out_ix` is 0. In row 0 the above and above-left pixels take the current and left values, so `out_iy` is 0.
- R6: With D = alpha^2 + Ix^2 + Iy^2 and D >= 2, `out_psi` (17 bits, unsigned, 16 fraction bits) equals floor(65536 / D).
- R7: When D is 0 or 1, `out_psi` saturates to 65535.
- R8: Each pixel accepted with `in_valid` high yields exactly one output with `out_valid` high, in input order, 22 clock edges after the edge that samples it. Cycles with `in_valid` low, whatever their data and flags, produce no output and do not change later results.
- R9: `out_sof` is high on the output of a pixel that entered with `in_sof`. `out_eol` is high on the output of a pixel that entered with `in_eol`. Both flags arrive with the same latency as the data and only while `out_valid` is high.
- R10: A new `alpha` value, held steady while a frame is streamed, applies to every pixel of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel pair is valid |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a line |
| in_prev | input | 8 | Pixel of the earlier frame |
| in_cur | input | 8 | Pixel of the later frame |
| alpha | input | 8 | Smoothing weight, unsigned integer |
| out_valid | output | 1 | Output record is valid |
| out_sof | output | 1 | Output belongs to the first pixel of a frame |
| out_eol | output | 1 | Output belongs to the last pixel of a line |
| out_ix | output | 9 | Horizontal gradient, signed |
| out_iy | output | 9 | Vertical gradient, signed |
| out_it | output | 9 | Temporal gradient, signed |
| out_psi | output | 17 | Reciprocal term, 16 fraction bits |

## Verification
Every result is due 22 edges after the edge that samples its pixel. The window, gradient, square, sum, 17 divider steps and output register each add one edge. The bench stamps each accepted pixel with the edge count at which it is sampled and compares the output at the half cycle where `out_valid` is observed. It checks the stamp difference against 22 and compares gradients, psi and flags in input order. Idle cycles inside a frame carry junk data and flags, so any leak shows up as an extra or shifted output. The bench lets the pipeline drain before it changes `alpha` or applies reset.

// File: rtl/ofg_pkg.sv
package ofg_pkg;
  // Eight +/-1 taps per gradient; normalisation by 4 is an arithmetic shift.
  localparam int KERNEL_SHIFT = 2;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ofg_linebuf.sv
// One-line memory, read-before-write at the same address: block RAM shaped.
module ofg_linebuf #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      rdata     <= mem[addr];
      mem[addr] <= wdata;
    end
  end
endmodule

// File: rtl/ofg_deriv.sv
module ofg_deriv import ofg_pkg::*; #(
  parameter int PIX_W  = 8,
  parameter int MAX_W  = 1024,
  localparam int AW    = $clog2(MAX_W),
  localparam int SUM_W = PIX_W + 3,
  localparam int DER_W = PIX_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sof,
  input  logic                    in_eol,
  input  logic [PIX_W-1:0]        in_prev,
  input  logic [PIX_W-1:0]        in_cur,
  output logic                    d_valid,
  output logic                    d_sof,
  output logic                    d_eol,
  output logic signed [DER_W-1:0] d_ix,
  output logic signed [DER_W-1:0] d_iy,
  output logic signed [DER_W-1:0] d_it
);
  // ---------------- position tracking ----------------
  logic [AW-1:0] x_cnt, x_now;
  logic          row_first, row_now;

  always_comb begin
    x_now   = in_sof ? '0 : x_cnt;
    row_now = in_sof | row_first;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      x_cnt     <= '0;
      row_first <= 1'b1;
    end else if (in_valid) begin
      if (in_eol) begin
        x_cnt     <= '0;
        row_first <= 1'b0;
      end else begin
        x_cnt     <= x_now + 1'b1;
        row_first <= row_now;
      end
    end
  end

  // ---------------- line memory (both frames side by side) ----------------
  logic [2*PIX_W-1:0] up_word;
  logic [PIX_W-1:0]   up_p, up_c;

  ofg_linebuf #(.DW(2*PIX_W), .DEPTH(MAX_W)) i_linebuf (
    .clk   (clk),
    .en    (in_valid),
    .addr  (x_now),
    .wdata ({in_prev, in_cur}),
    .rdata (up_word)
  );
  assign {up_p, up_c} = up_word;

  // ---------------- window registers (stage A) ----------------
  logic [PIX_W-1:0] w_cc, w_cp, w_lc, w_lp, w_ulc, w_ulp;
  logic             a_col0, a_row0, a_sof, a_eol, a_valid;

  always_ff @(posedge clk) begin
    if (in_valid) begin
      w_cc   <= in_cur;
      w_cp   <= in_prev;
      w_lc   <= w_cc;
      w_lp   <= w_cp;
      w_ulc  <= up_c;
      w_ulp  <= up_p;
      a_col0 <= (x_now == '0);
      a_row0 <= row_now;
      a_sof  <= in_sof;
      a_eol  <= in_eol;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) a_valid <= 1'b0;
    else     a_valid <= in_valid;
  end

  // ---------------- edge replication ----------------
  logic [PIX_W-1:0] lc1, lp1, ulc1, ulp1, uc2, up2, ulc2, ulp2;

  always_comb begin
    lc1  = a_col0 ? w_cc : w_lc;
    lp1  = a_col0 ? w_cp : w_lp;
    ulc1 = a_col0 ? up_c : w_ulc;
    ulp1 = a_col0 ? up_p : w_ulp;
    uc2  = a_row0 ? w_cc : up_c;
    up2  = a_row0 ? w_cp : up_p;
    ulc2 = a_row0 ? lc1  : ulc1;
    ulp2 = a_row0 ? lp1  : ulp1;
  end

  // ---------------- kernels ----------------
  function automatic logic signed [SUM_W-1:0] ext(input logic [PIX_W-1:0] v);
    return $signed({{(SUM_W-PIX_W){1'b0}}, v});
  endfunction

  logic signed [SUM_W-1:0] sx, sy, st;

  always_comb begin
    sx = (ext(w_cc) - ext(lc1)) + (ext(uc2) - ext(ulc2))
       + (ext(w_cp) - ext(lp1)) + (ext(up2) - ext(ulp2));
    sy = (ext(w_cc) - ext(uc2)) + (ext(lc1) - ext(ulc2))
       + (ext(w_cp) - ext(up2)) + (ext(lp1) - ext(ulp2));
    st = (ext(w_cc) - ext(w_cp)) + (ext(lc1) - ext(lp1))
       + (ext(uc2)  - ext(up2))  + (ext(ulc2) - ext(ulp2));
  end

  // ---------------- gradient registers (stage B) ----------------
  always_ff @(posedge clk) begin
    d_ix <= DER_W'(sx >>> KERNEL_SHIFT);
    d_iy <= DER_W'(sy >>> KERNEL_SHIFT);
    d_it <= DER_W'(st >>> KERNEL_SHIFT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      d_valid <= 1'b0;
      d_sof   <= 1'b0;
      d_eol   <= 1'b0;
    end else begin
      d_valid <= a_valid;
      d_sof   <= a_valid & a_sof;
      d_eol   <= a_valid & a_eol;
    end
  end

  // Column 0 copies the current column, so the horizontal gradient vanishes.
  assert_col0_flat_R5: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_col0) |=> (d_ix == '0));

  // Row 0 copies the current row, so the vertical gradient vanishes.
  assert_row0_flat_R5: assert property (@(posedge clk) disable iff (rst)
    (a_valid && a_row0) |=> (d_iy == '0));

  assert_deriv_range_R2: assert property (@(posedge clk) disable iff (rst)
    d_valid |-> (d_ix >= -(2**PIX_W - 1)) && (d_ix <= (2**PIX_W - 1)));
endmodule

// File: rtl/ofg_recip.sv
// Restoring divider, one quotient bit per registered step: floor(2^FRAC / den).
module ofg_recip #(
  parameter int DEN_W = 18,
  parameter int FRAC  = 16,
  localparam int QB   = FRAC + 1,
  localparam int RW   = DEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [DEN_W-1:0] den,
  output logic [QB-1:0]    psi
);
  localparam logic [QB-1:0] PMAX = {1'b0, {FRAC{1'b1}}};
  localparam logic [63:0]   NUM  = 64'd1 << FRAC;

  logic [DEN_W-1:0] rem_s [1:QB];
  logic [DEN_W-1:0] den_s [1:QB];
  logic [QB-1:0]    q_s   [1:QB];
  logic             sat_s [1:QB];
  logic             vld_s [1:QB];

  for (genvar i = 0; i < QB; i++) begin : g_step
    logic [DEN_W-1:0] r_in, d_in;
    logic [QB-1:0]    q_in;
    logic             s_in, v_in, ge;
    logic [RW-1:0]    trial;

    if (i == 0) begin : g_head
      assign r_in = '0;
      assign d_in = den;
      assign q_in = '0;
      assign s_in = (den <= DEN_W'(1));
      assign v_in = in_valid;
    end else begin : g_body
      assign r_in = rem_s[i];
      assign d_in = den_s[i];
      assign q_in = q_s[i];
      assign s_in = sat_s[i];
      assign v_in = vld_s[i];
    end

    // Numerator 2^FRAC: only its leading bit, fed on the first step, is set.
    assign trial = {r_in, (i == 0) ? 1'b1 : 1'b0};
    assign ge    = trial >= {1'b0, d_in};

    always_ff @(posedge clk) begin
      rem_s[i+1] <= ge ? DEN_W'(trial - {1'b0, d_in}) : DEN_W'(trial);
      den_s[i+1] <= d_in;
      q_s[i+1]   <= QB'({q_in, ge});
      sat_s[i+1] <= s_in;
    end

    always_ff @(posedge clk) begin
      if (rst) vld_s[i+1] <= 1'b0;
      else     vld_s[i+1] <= v_in;
    end
  end

  always_ff @(posedge clk) begin
    psi <= sat_s[QB] ? PMAX : q_s[QB];
  end

  // Quotient and remainder reconstruct the numerator exactly.
  logic [63:0] recon;
  assign recon = 64'(q_s[QB]) * 64'(den_s[QB]) + 64'(rem_s[QB]);

  assert_quot_exact_R6: assert property (@(posedge clk) disable iff (rst)
    (vld_s[QB] && !sat_s[QB]) |-> (recon == NUM) && (rem_s[QB] < den_s[QB]));
endmodule

// File: rtl/ofg_delay.sv
module ofg_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst)         pipe[k] <= '0;
      else if (k == 0) pipe[k] <= din;
      else             pipe[k] <= pipe[(k == 0) ? 0 : k-1];
    end
  end

  assign dout = pipe[DEPTH-1];
endmodule

// File: rtl/optflow_grad_frontend.sv
module optflow_grad_frontend import ofg_pkg::*; #(
  parameter int PIX_W    = 8,
  parameter int ALPHA_W  = 8,
  parameter int MAX_W    = 1024,
  parameter int PSI_FRAC = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_sof,
  input  logic                  in_eol,
  input  logic [PIX_W-1:0]      in_prev,
  input  logic [PIX_W-1:0]      in_cur,
  input  logic [ALPHA_W-1:0]    alpha,
  output logic                  out_valid,
  output logic                  out_sof,
  output logic                  out_eol,
  output logic signed [PIX_W:0] out_ix,
  output logic signed [PIX_W:0] out_iy,
  output logic signed [PIX_W:0] out_it,
  output logic [PSI_FRAC:0]     out_psi
);
  localparam int DER_W = PIX_W + 1;
  localparam int SQ_W  = 2 * PIX_W;
  localparam int ASQ_W = 2 * ALPHA_W;
  localparam int DEN_W = max2(SQ_W, ASQ_W) + 2;
  localparam int QB    = PSI_FRAC + 1;
  // square stage + sum stage + divider steps + divider output register
  localparam int SIDE_DLY = 2 + QB + 1;
  localparam int SIDE_W   = 3 + 3 * DER_W;

  logic                    d_valid, d_sof, d_eol;
  logic signed [DER_W-1:0] d_ix, d_iy, d_it;

  ofg_deriv #(.PIX_W(PIX_W), .MAX_W(MAX_W)) i_deriv (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_eol   (in_eol),
    .in_prev  (in_prev),
    .in_cur   (in_cur),
    .d_valid  (d_valid),
    .d_sof    (d_sof),
    .d_eol    (d_eol),
    .d_ix     (d_ix),
    .d_iy     (d_iy),
    .d_it     (d_it)
  );

  // ---------------- squares (stage C) ----------------
  logic [SQ_W-1:0]  c_sqx, c_sqy;
  logic [ASQ_W-1:0] c_asq;
  logic             c_valid;

  always_ff @(posedge clk) begin
    c_sqx <= SQ_W'(d_ix * d_ix);
    c_sqy <= SQ_W'(d_iy * d_iy);
    c_asq <= ASQ_W'(alpha * alpha);
  end

  // ---------------- denominator (stage D) ----------------
  logic [DEN_W-1:0] e_den;
  logic             e_valid;

  always_ff @(posedge clk) begin
    e_den <= DEN_W'(c_sqx) + DEN_W'(c_sqy) + DEN_W'(c_asq);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_valid <= 1'b0;
      e_valid <= 1'b0;
    end else begin
      c_valid <= d_valid;
      e_valid <= c_valid;
    end
  end

  ofg_recip #(.DEN_W(DEN_W), .FRAC(PSI_FRAC)) i_recip (
    .clk      (clk),
    .rst      (rst),
    .in_valid (e_valid),
    .den      (e_den),
    .psi      (out_psi)
  );

  // ---------------- gradients and flags ride alongside ----------------
  logic [SIDE_W-1:0] side_in, side_out;
  assign side_in = {d_valid, d_sof, d_eol, d_ix, d_iy, d_it};

  ofg_delay #(.W(SIDE_W), .DEPTH(SIDE_DLY)) i_side_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (side_in),
    .dout (side_out)
  );

  assign {out_valid, out_sof, out_eol, out_ix, out_iy, out_it} = side_out;

  assert_side_valid_R9: assert property (@(posedge clk) disable iff (rst)
    (out_sof || out_eol) |-> out_valid);
endmodule

// File: tb/test_optflow_grad_frontend.sv
module test_optflow_grad_frontend;
  localparam int LAT  = 22;
  localparam int NMAX = 1024;
  localparam int PMAX = 65535;
  localparam int NT   = 9;

  // {width, height, alpha, pattern, gap}
  // pattern: 0 flat, 1 hashed, 2 vertical stripes, 3 dark-to-bright, 4 horizontal stripes
  localparam logic [31:0] TBL [NT] = '{
    {8'd6, 8'd4, 8'd3,   4'd1, 4'd0},  // general texture, R2 R3 R4 R6
    {8'd8, 8'd3, 8'd0,   4'd0, 4'd0},  // D = 0, R7
    {8'd5, 8'd3, 8'd1,   4'd0, 4'd0},  // D = 1, R7; alpha changed, R10
    {8'd8, 8'd3, 8'd0,   4'd2, 4'd0},  // |Ix| = 255, psi = 1
    {8'd4, 8'd3, 8'd20,  4'd3, 4'd0},  // It = 255
    {8'd7, 8'd5, 8'd10,  4'd1, 4'd1},  // idle cycles inside the frame, R8
    {8'd1, 8'd3, 8'd5,   4'd1, 4'd0},  // single column, R5 R9
    {8'd9, 8'd1, 8'd255, 4'd1, 4'd0},  // single row, alpha maximum
    {8'd3, 8'd4, 8'd2,   4'd4, 4'd0}   // |Iy| = 255, R3
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [7:0] in_prev = '0, in_cur = '0, alpha = '0;
  logic       out_valid, out_sof, out_eol;
  logic signed [8:0] out_ix, out_iy, out_it;
  logic [16:0] out_psi;

  always #5 clk = ~clk;

  optflow_grad_frontend i_optflow_grad_frontend (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
    .in_prev(in_prev), .in_cur(in_cur), .alpha(alpha),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_ix(out_ix), .out_iy(out_iy), .out_it(out_it), .out_psi(out_psi)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int wr = 0, rd = 0;
  int e_in [NMAX];
  int e_ix [NMAX], e_iy [NMAX], e_it [NMAX], e_psi [NMAX];
  int e_x  [NMAX], e_y  [NMAX], e_sof [NMAX], e_eol [NMAX], e_pt [NMAX];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic int pixv(input int mode, input int fr, input int x, input int y, input int seed);
    case (mode)
      0:       return 100;
      1:       return (x*37 + y*91 + fr*53 + x*y*11 + seed*17) & 255;
      2:       return (x & 1) ? 255 : 0;
      3:       return fr ? 255 : 0;
      default: return (y & 1) ? 255 : 0;
    endcase
  endfunction

  task automatic drive_frame(input int w, input int h, input int a, input int mode,
                             input int gap, input int seed, input bit rec, input int fidx);
    for (int y = 0; y < h; y++) begin
      for (int x = 0; x < w; x++) begin
        int xl, yu, cc, cp, lc, lp, uc, up, ulc, ulp, ix, iy, it, dd;
        if (gap != 0 && (x % 3) == 1) begin
          @(negedge clk);
          in_valid = 1'b0; in_sof = 1'b1; in_eol = 1'b1;
          in_prev = 8'hA5; in_cur = 8'h3C;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (x == 0 && y == 0);
        in_eol   = (x == w-1);
        in_prev  = 8'(pixv(mode, 0, x, y, seed));
        in_cur   = 8'(pixv(mode, 1, x, y, seed));
        if (rec) begin
          xl  = (x == 0) ? x : x-1;
          yu  = (y == 0) ? y : y-1;
          cc  = pixv(mode, 1, x, y, seed);   cp  = pixv(mode, 0, x, y, seed);
          lc  = pixv(mode, 1, xl, y, seed);  lp  = pixv(mode, 0, xl, y, seed);
          uc  = pixv(mode, 1, x, yu, seed);  up  = pixv(mode, 0, x, yu, seed);
          ulc = pixv(mode, 1, xl, yu, seed); ulp = pixv(mode, 0, xl, yu, seed);
          ix = ((cc-lc) + (uc-ulc) + (cp-lp) + (up-ulp)) >>> 2;
          iy = ((cc-uc) + (lc-ulc) + (cp-up) + (lp-ulp)) >>> 2;
          it = ((cc-cp) + (lc-lp) + (uc-up) + (ulc-ulp)) >>> 2;
          dd = a*a + ix*ix + iy*iy;
          e_in[wr]  = cyc;
          e_ix[wr]  = ix; e_iy[wr] = iy; e_it[wr] = it;
          e_psi[wr] = (dd <= 1) ? PMAX : (65536 / dd);
          e_pt[wr]  = (dd <= 1) ? 2 : ((fidx > 0) ? 1 : 0);
          e_x[wr] = x; e_y[wr] = y;
          e_sof[wr] = (x == 0 && y == 0) ? 1 : 0;
          e_eol[wr] = (x == w-1) ? 1 : 0;
          wr++;
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
  endtask

  // Output monitor, half a cycle away from the active edge.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rd >= wr) begin
        check(1'b0, "R8 R1 unexpected output", 1, 0);
      end else begin
        check(cyc - e_in[rd] == LAT, "R8 latency", cyc - e_in[rd], LAT);
        check(int'(out_ix) == e_ix[rd], (e_x[rd] == 0) ? "R5 ix" : "R2 ix", int'(out_ix), e_ix[rd]);
        check(int'(out_iy) == e_iy[rd], (e_y[rd] == 0) ? "R5 iy" : "R3 iy", int'(out_iy), e_iy[rd]);
        check(int'(out_it) == e_it[rd], "R4 it", int'(out_it), e_it[rd]);
        check(int'(out_psi) == e_psi[rd],
              (e_pt[rd] == 2) ? "R7 psi" : ((e_pt[rd] == 1) ? "R10 psi" : "R6 psi"),
              int'(out_psi), e_psi[rd]);
        check(int'(out_sof) == e_sof[rd], "R9 sof", int'(out_sof), e_sof[rd]);
        check(int'(out_eol) == e_eol[rd], "R9 eol", int'(out_eol), e_eol[rd]);
        rd++;
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R8 watchdog expired", cyc, 150000);
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid in reset", int'(out_valid), 0);
    check(out_sof == 1'b0, "R1 sof in reset", int'(out_sof), 0);
    check(out_eol == 1'b0, "R1 eol in reset", int'(out_eol), 0);
    rst = 1'b0;

    for (int i = 0; i < NT; i++) begin
      @(negedge clk);
      alpha = TBL[i][15:8];
      drive_frame(int'(TBL[i][31:24]), int'(TBL[i][23:16]), int'(TBL[i][15:8]),
                  int'(TBL[i][7:4]), int'(TBL[i][3:0]), i, 1'b1, i);
      while (rd < wr) @(negedge clk);
      repeat (4) @(negedge clk);
    end

    // R1: pixels in flight when reset rises must vanish.
    drive_frame(5, 1, 7, 1, 0, 3, 1'b0, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R1 valid during mid-run reset", int'(out_valid), 0);
    rst = 1'b0;
    repeat (40) @(negedge clk);
    check(out_valid == 1'b0, "R1 no output after flush", int'(out_valid), 0);

    // Recovery after reset: a fresh frame is processed normally.
    @(negedge clk);
    alpha = 8'd4;
    drive_frame(5, 3, 4, 1, 1, 11, 1'b1, 1);
    while (rd < wr) @(negedge clk);
    repeat (30) @(negedge clk);

    check(rd == wr, "R8 one output per accepted pixel", rd, wr);
    summary();
    $finish;
  end
endmodule